// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel that sits beside a general-purpose timer counter. Each clock it looks at the counter value, the counting direction, a tick strobe saying that the counter advanced or was reloaded, and a compare value. A three-bit mode selects how these drive an active-high reference level. That level is held in a register, so it changes one clock after the inputs that cause it. The reference then feeds a main output and a complementary output, each with its own polarity bit.

The mode field is written through a simple write strobe. A lock input can protect it. An external clear input, gated by a clear-enable bit, can pull the reference low at any time. The counter, input capture, dead-time generation and register bus access are outside this block.

Top module: `oc_channel`

## Requirements
- R1: After a synchronous active-low reset the reference is 0 and the mode is frozen (000). With both polarity bits 0, the main output reads 0 and the complementary output reads 1.
- R2: Mode 100 drives the reference to 0 and mode 101 drives it to 1 on the next clock, whatever the compare result.
- R3: In mode 001 the reference goes to 1 on the clock after a cycle in which the tick is high and the counter equals the compare value. Equality without a tick has no effect.
- R4: In mode 010 the reference goes to 0 on the clock after a ticked cycle in which the counter equals the compare value. A ticked cycle without equality leaves it unchanged.
- R5: In mode 011 the reference inverts once per arrival at equality. Further ticked cycles with the counter still equal to the compare value do not invert it again.
- R6: In mode 110, counting up (direction input 0), the target level is 1 while counter < compare and 0 otherwise. Counting down (direction input 1), it is 0 while counter > compare and 1 otherwise.
- R7: In mode 111 the target level is the inverse of the mode 110 target for the same counter, compare value and direction.
- R8: In modes 110 and 111 the reference is loaded with the target level only on the clock after the comparison result changes, or on the first clock in a PWM mode after frozen mode. Otherwise it holds, even when the reference and the target differ.
- R9: In mode 000 the reference holds its level regardless of compare matches.
- R10: With clear-enable 1, a high external clear forces the reference to 0 on the next clock. With clear-enable 0, the external clear has no effect.
- R11: An enabled clear takes priority over a set, toggle or force-high in the same cycle.
- R12: The main output is the reference XOR the main polarity bit. The complementary output is the inverted reference XOR the complementary polarity bit, so a polarity bit of 1 makes that output active low.
- R13: A mode write is ignored when the lock level is 3 and the channel is selected as an output. It takes effect on the next clock when the lock level is below 3 or the channel is not an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current timer counter value |
| cnt_dn | input | 1 | Counting direction, 1 = down |
| cnt_tick | input | 1 | Counter advanced or reloaded this cycle |
| cmp_val | input | CNT_W | Compare value |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode to write |
| lock_lvl | input | 2 | Write-protect level |
| chan_is_out | input | 1 | Channel is selected as an output |
| clr_en | input | 1 | Enables the external clear |
| ext_clr | input | 1 | External clear, active high level |
| pol_main | input | 1 | Main output polarity, 1 = active low |
| pol_comp | input | 1 | Complementary output polarity, 1 = active low |
| oc_ref | output | 1 | Registered active-high reference |
| oc_main | output | 1 | Main output |
| oc_comp | output | 1 | Complementary output |

## Verification
The compare logic is driven with counter values below, at and above the compare value in both directions. This separates the strict and inclusive comparisons that make PWM 1 and PWM 2 differ between up and down counting. Equality is presented with and without the tick, and held across several ticks. This separates a real match event from a stalled counter and shows that toggle acts only once. Mode switches into PWM from a force mode and from frozen mode show the rule that only a change in the comparison, or leaving frozen mode, loads the reference. Clear and lock patterns are each paired with a stimulus that would otherwise move the reference.

// File: rtl/oc_pkg.sv
// Package: shared types for the output compare channel.
// Assumes: mode encoding is fixed by the three-bit mode field.
package oc_pkg;

    // Reference behaviour selected by the mode field.
    typedef enum logic [2:0] {
        OCM_FROZEN  = 3'b000,
        OCM_SET     = 3'b001,
        OCM_CLEAR   = 3'b010,
        OCM_TOGGLE  = 3'b011,
        OCM_FORCE_L = 3'b100,
        OCM_FORCE_H = 3'b101,
        OCM_PWM1    = 3'b110,
        OCM_PWM2    = 3'b111
    } oc_mode_e;

    // Lock level at which the mode field becomes read-only.
    localparam logic [1:0] LOCK_MODE_LVL = 2'd3;

endpackage

// File: rtl/oc_mode_reg.sv
// Module: mode field register with write protection.
// Does: stores the channel mode and accepts writes unless the lock level is
// the top level while the channel is selected as an output.
// Assumes: one write per strobe; the reset value is frozen mode.
module oc_mode_reg
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    input  logic [1:0] lock_lvl,
    input  logic       chan_is_out,
    output oc_mode_e   mode_q
);

    logic wr_blocked;
    logic wr_take;

    // Purpose: decide whether a presented write is accepted.
    always_comb begin
        wr_blocked = (lock_lvl == LOCK_MODE_LVL) && chan_is_out;
        wr_take    = wr_en && !wr_blocked;
    end

    // Purpose: hold the mode, loading it on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OCM_FROZEN;
        end else if (wr_take) begin
            mode_q <= oc_mode_e'(wr_data);
        end
    end

    // R13
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_lvl == LOCK_MODE_LVL) && chan_is_out) |=> $stable(mode_q));

endmodule

// File: rtl/oc_cmp.sv
// Module: compare front end.
// Does: produces a one-shot match event on the first ticked cycle in which the
// counter equals the compare value, plus the direction-aware PWM comparison
// and a flag that it changed since the previous cycle.
// Assumes: counter and compare value are unsigned and of equal width.
module oc_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_dn,
    input  logic             cnt_tick,
    output logic             match_evt,
    output logic             pwm_res,
    output logic             pwm_chg
);

    logic eq_now;
    logic lt_now;
    logic gt_now;
    logic eq_seen;
    logic res_q;

    // Purpose: raw magnitude comparisons.
    always_comb begin
        eq_now = (cnt_val == cmp_val);
        lt_now = (cnt_val <  cmp_val);
        gt_now = (cnt_val >  cmp_val);
    end

    // Purpose: PWM 1 active condition, strict when counting up and inclusive when counting down.
    always_comb begin
        pwm_res = cnt_dn ? !gt_now : lt_now;
        pwm_chg = (pwm_res != res_q);
    end

    // Purpose: a match event needs a tick and a fresh arrival at equality.
    always_comb begin
        match_evt = cnt_tick && eq_now && !eq_seen;
    end

    // Purpose: remember equality as of the last tick, and the last comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_seen <= 1'b0;
            res_q   <= 1'b0;
        end else begin
            if (cnt_tick) begin
                eq_seen <= eq_now;
            end
            res_q <= pwm_res;
        end
    end

    // R5
    match_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> !match_evt);

endmodule

// File: rtl/oc_ref_gen.sv
// Module: reference level generator.
// Does: applies the selected mode to the match event and PWM comparison,
// with an enabled external clear overriding everything, and registers the
// resulting active-high reference.
// Assumes: match_evt and pwm_chg come from oc_cmp in the same cycle.
module oc_ref_gen
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  oc_mode_e mode_q,
    input  logic     match_evt,
    input  logic     pwm_res,
    input  logic     pwm_chg,
    input  logic     clr_en,
    input  logic     ext_clr,
    output logic     ref_q
);

    logic ref_d;
    logic was_frozen;
    logic clr_hit;
    logic pwm_lvl;

    // Purpose: next reference level from the mode, then the clear override.
    always_comb begin
        clr_hit = clr_en && ext_clr;
        pwm_lvl = (mode_q == OCM_PWM1) ? pwm_res : !pwm_res;
        ref_d   = ref_q;
        unique case (mode_q)
            OCM_FROZEN:  ref_d = ref_q;
            OCM_SET:     if (match_evt) ref_d = 1'b1;
            OCM_CLEAR:   if (match_evt) ref_d = 1'b0;
            OCM_TOGGLE:  if (match_evt) ref_d = !ref_q;
            OCM_FORCE_L: ref_d = 1'b0;
            OCM_FORCE_H: ref_d = 1'b1;
            OCM_PWM1,
            OCM_PWM2:    if (pwm_chg || was_frozen) ref_d = pwm_lvl;
        endcase
        if (clr_hit) begin
            ref_d = 1'b0;
        end
    end

    // Purpose: register the reference and note whether the mode was frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q      <= 1'b0;
            was_frozen <= 1'b1;
        end else begin
            ref_q      <= ref_d;
            was_frozen <= (mode_q == OCM_FROZEN);
        end
    end

    // R2
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == OCM_FORCE_H) && !(clr_en && ext_clr)) |=> ref_q);

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ext_clr) |=> !ref_q);

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == OCM_FROZEN) && !(clr_en && ext_clr)) |=> $stable(ref_q));

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == OCM_TOGGLE) && match_evt && !(clr_en && ext_clr))
        |=> (ref_q != $past(ref_q)));

    // R8
    pwm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode_q == OCM_PWM1) || (mode_q == OCM_PWM2)) && !pwm_chg
         && !was_frozen && !(clr_en && ext_clr)) |=> $stable(ref_q));

endmodule

// File: rtl/oc_channel.sv
// Module: output compare channel top.
// Does: joins the mode register, compare front end and reference generator,
// and derives main and complementary outputs with separate polarity.
// Assumes: counter, direction and tick come from an external timer counter.
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_dn,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             mode_wr,
    input  logic [2:0]       mode_wdata,
    input  logic [1:0]       lock_lvl,
    input  logic             chan_is_out,
    input  logic             clr_en,
    input  logic             ext_clr,
    input  logic             pol_main,
    input  logic             pol_comp,
    output logic             oc_ref,
    output logic             oc_main,
    output logic             oc_comp
);

    oc_mode_e mode_q;
    logic     match_evt;
    logic     pwm_res;
    logic     pwm_chg;

    oc_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (mode_wr),
        .wr_data     (mode_wdata),
        .lock_lvl    (lock_lvl),
        .chan_is_out (chan_is_out),
        .mode_q      (mode_q)
    );

    oc_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .cmp_val   (cmp_val),
        .cnt_dn    (cnt_dn),
        .cnt_tick  (cnt_tick),
        .match_evt (match_evt),
        .pwm_res   (pwm_res),
        .pwm_chg   (pwm_chg)
    );

    oc_ref_gen u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .match_evt (match_evt),
        .pwm_res   (pwm_res),
        .pwm_chg   (pwm_chg),
        .clr_en    (clr_en),
        .ext_clr   (ext_clr),
        .ref_q     (oc_ref)
    );

    // Purpose: apply output polarity to the reference and its complement.
    always_comb begin
        oc_main = oc_ref ^ pol_main;
        oc_comp = !oc_ref ^ pol_comp;
    end

    // R12
    comp_oppose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_main == pol_comp) |-> (oc_main != oc_comp));

endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_dn = 1'b0;
    logic         cnt_tick = 1'b0;
    logic [W-1:0] cmp_val = 16'd10;
    logic         mode_wr = 1'b0;
    logic [2:0]   mode_wdata = 3'b000;
    logic [1:0]   lock_lvl = 2'd0;
    logic         chan_is_out = 1'b1;
    logic         clr_en = 1'b0;
    logic         ext_clr = 1'b0;
    logic         pol_main = 1'b0;
    logic         pol_comp = 1'b0;
    logic         oc_ref;
    logic         oc_main;
    logic         oc_comp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = !clk;

    oc_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_dn(cnt_dn),
        .cnt_tick(cnt_tick), .cmp_val(cmp_val), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .lock_lvl(lock_lvl), .chan_is_out(chan_is_out),
        .clr_en(clr_en), .ext_clr(ext_clr), .pol_main(pol_main),
        .pol_comp(pol_comp), .oc_ref(oc_ref), .oc_main(oc_main), .oc_comp(oc_comp)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One clock edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Write a mode; it is in force from the next edge, visible on the ref one edge later.
    task automatic write_mode(input logic [2:0] m);
        mode_wr = 1'b1;
        mode_wdata = m;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic apply_mode(input logic [2:0] m);
        cnt_tick = 1'b0;
        write_mode(m);
        step();
    endtask

    task automatic count(input int v, input logic dn, input logic tk);
        cnt_val = v[W-1:0];
        cnt_dn = dn;
        cnt_tick = tk;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        check("R1 ref after reset", oc_ref, 1'b0);
        check("R1 main after reset", oc_main, 1'b0);
        check("R1 comp after reset", oc_comp, 1'b1);
        cnt_val = 16'd4;
        step();
        check("R1 mode frozen: ref holds", oc_ref, 1'b0);
    endtask

    task automatic t_force();
        apply_mode(3'b101);
        check("R2 force high", oc_ref, 1'b1);
        apply_mode(3'b100);
        check("R2 force low", oc_ref, 1'b0);
        apply_mode(3'b101);
        count(10, 1'b0, 1'b1);
        check("R2 force high ignores match", oc_ref, 1'b1);
    endtask

    task automatic t_frozen();
        apply_mode(3'b101);
        apply_mode(3'b000);
        check("R9 frozen keeps high", oc_ref, 1'b1);
        count(9, 1'b0, 1'b1);
        count(10, 1'b0, 1'b1);
        count(11, 1'b0, 1'b1);
        check("R9 frozen ignores match", oc_ref, 1'b1);
    endtask

    task automatic t_set();
        apply_mode(3'b100);
        apply_mode(3'b001);
        count(9, 1'b0, 1'b1);
        check("R3 no match stays low", oc_ref, 1'b0);
        count(10, 1'b0, 1'b0);
        check("R3 equality without tick ignored", oc_ref, 1'b0);
        count(10, 1'b0, 1'b1);
        check("R3 ticked match sets", oc_ref, 1'b1);
    endtask

    task automatic t_clear_match();
        apply_mode(3'b101);
        apply_mode(3'b010);
        count(4, 1'b0, 1'b1);
        check("R4 no match stays high", oc_ref, 1'b1);
        count(10, 1'b0, 1'b1);
        check("R4 match clears", oc_ref, 1'b0);
    endtask

    task automatic t_toggle();
        apply_mode(3'b100);
        apply_mode(3'b011);
        count(3, 1'b0, 1'b1);
        count(10, 1'b0, 1'b1);
        check("R5 first match toggles", oc_ref, 1'b1);
        count(10, 1'b0, 1'b1);
        count(10, 1'b0, 1'b1);
        check("R5 stalled match no retoggle", oc_ref, 1'b1);
        count(11, 1'b0, 1'b1);
        count(10, 1'b0, 1'b1);
        check("R5 new arrival toggles back", oc_ref, 1'b0);
    endtask

    task automatic t_pwm1();
        cmp_val = 16'd5;
        apply_mode(3'b100);
        cnt_val = 16'd2;
        cnt_dn = 1'b0;
        apply_mode(3'b000);
        apply_mode(3'b110);
        check("R8 entry from frozen loads PWM1 level", oc_ref, 1'b1);
        count(5, 1'b0, 1'b1);
        check("R6 up cnt==cmp low", oc_ref, 1'b0);
        count(5, 1'b1, 1'b1);
        check("R6 down cnt==cmp high", oc_ref, 1'b1);
        count(6, 1'b1, 1'b1);
        check("R6 down cnt>cmp low", oc_ref, 1'b0);
        count(4, 1'b0, 1'b1);
        check("R6 up cnt<cmp high", oc_ref, 1'b1);
    endtask

    task automatic t_pwm2();
        cmp_val = 16'd5;
        apply_mode(3'b101);
        cnt_val = 16'd2;
        cnt_dn = 1'b0;
        apply_mode(3'b000);
        apply_mode(3'b111);
        check("R7 up cnt<cmp low", oc_ref, 1'b0);
        count(6, 1'b0, 1'b1);
        check("R7 up cnt>cmp high", oc_ref, 1'b1);
        count(6, 1'b1, 1'b1);
        check("R7 down cnt>cmp high", oc_ref, 1'b1);
        count(4, 1'b1, 1'b1);
        check("R7 down cnt<cmp low", oc_ref, 1'b0);
    endtask

    task automatic t_pwm_hold();
        cmp_val = 16'd5;
        cnt_val = 16'd8;
        cnt_dn = 1'b0;
        apply_mode(3'b101);
        apply_mode(3'b110);
        step();
        check("R8 no comparison change holds ref", oc_ref, 1'b1);
        count(3, 1'b0, 1'b1);
        check("R8 change to active keeps high", oc_ref, 1'b1);
        count(7, 1'b0, 1'b1);
        check("R8 change to inactive loads low", oc_ref, 1'b0);
    endtask

    task automatic t_ext_clear();
        apply_mode(3'b101);
        ext_clr = 1'b1;
        clr_en = 1'b0;
        step();
        check("R10 clear ignored when disabled", oc_ref, 1'b1);
        clr_en = 1'b1;
        step();
        check("R11 clear beats force high", oc_ref, 1'b0);
        ext_clr = 1'b0;
        step();
        check("R10 release restores force", oc_ref, 1'b1);
        clr_en = 1'b0;
        cmp_val = 16'd10;
        apply_mode(3'b100);
        apply_mode(3'b001);
        count(9, 1'b0, 1'b1);
        clr_en = 1'b1;
        ext_clr = 1'b1;
        count(10, 1'b0, 1'b1);
        check("R11 clear beats set event", oc_ref, 1'b0);
        ext_clr = 1'b0;
        clr_en = 1'b0;
        apply_mode(3'b011);
        count(9, 1'b0, 1'b1);
        clr_en = 1'b1;
        ext_clr = 1'b1;
        count(10, 1'b0, 1'b1);
        check("R11 clear beats toggle event", oc_ref, 1'b0);
        ext_clr = 1'b0;
        clr_en = 1'b0;
    endtask

    task automatic t_polarity();
        apply_mode(3'b101);
        pol_main = 1'b0; pol_comp = 1'b0; #1;
        check("R12 main active high", oc_main, 1'b1);
        check("R12 comp active high", oc_comp, 1'b0);
        pol_main = 1'b1; pol_comp = 1'b1; #1;
        check("R12 main active low", oc_main, 1'b0);
        check("R12 comp active low", oc_comp, 1'b1);
        pol_main = 1'b0; pol_comp = 1'b0;
    endtask

    task automatic t_lock();
        apply_mode(3'b101);
        lock_lvl = 2'd3;
        chan_is_out = 1'b1;
        apply_mode(3'b100);
        step();
        check("R13 locked write ignored", oc_ref, 1'b1);
        chan_is_out = 1'b0;
        apply_mode(3'b100);
        check("R13 write taken when not output", oc_ref, 1'b0);
        chan_is_out = 1'b1;
        lock_lvl = 2'd2;
        apply_mode(3'b101);
        check("R13 write taken below lock 3", oc_ref, 1'b1);
        lock_lvl = 2'd0;
    endtask

    initial begin
        t_reset();
        t_force();
        t_frozen();
        t_set();
        t_clear_match();
        t_toggle();
        t_pwm1();
        t_pwm2();
        t_pwm_hold();
        t_ext_clear();
        t_polarity();
        t_lock();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule